// File: doc/BRIEF.md
# Shared GPIO Pin Peripheral Multiplexer

This block controls a group of bidirectional pins. Each pin is shared by a general-purpose port and two peripheral functions. The port has three registers that a simple register bus can write and read back: a direction register, an output data latch and an analog-configuration register. A fourth address is the port address. Reading it returns the synchronized pin level, and writing it loads the data latch.

For each pin, a fixed-priority owner selector decides who drives it. Peripheral A comes first, then peripheral B, then the port. The selected owner supplies both the output data and the output enable. This is done by two separate multiplexer chains. The pad is modelled as three signals: `pad_out`, `pad_oe` and `pad_in`.

The pin level always reaches both peripheral inputs, whoever drives the pin. A pin whose analog-configuration bit is 0 is treated as analog. Its digital input paths then read 0, whether or not any converter is active.

The per-pin ownership is an enumerated state, re-evaluated every cycle from the enables. It has three states:
- `OWN_PERA`: entered whenever the pin's bit in `pera_en` is 1.
- `OWN_PERB`: entered when `perb_en` is 1 and `pera_en` is 0.
- `OWN_PORT`: entered when both enables are 0.

Top module: `shared_pin_mux`

## Requirements
- R1: After reset, the direction register reads all ones, the data latch and the analog-configuration register read 0, and `pad_oe` is 0 while no peripheral is enabled.
- R2: When the port owns a pin, `pad_out` equals the latch bit and `pad_oe` equals the inverse of the direction bit. A direction bit of 1 means input, with the output disabled.
- R3: When `pera_en` is 1 for a pin, `pad_out` and `pad_oe` equal `pera_out` and `pera_oe`, whatever the port and peripheral B are doing.
- R4: When `perb_en` is 1 and `pera_en` is 0 for a pin, `pad_out` and `pad_oe` equal `perb_out` and `perb_oe`.
- R5: When both enables are 1 for a pin, peripheral A drives both `pad_out` and `pad_oe`.
- R6: A write with `bus_addr`=1 (latch) or `bus_addr`=2 (port) loads the data latch on that clock edge. A read with `bus_addr`=1 returns the stored latch value.
- R7: A read with `bus_addr`=0 returns the direction register, and a read with `bus_addr`=3 returns the analog-configuration register. Each returns the value written at that same address. Reads are combinational.
- R8: A read with `bus_addr`=2 returns the pad level through a two-flop synchronizer. A change on `pad_in` is visible after two rising clock edges, and not after one.
- R9: `pera_in` and `perb_in` follow `pad_in` combinationally for digital pins, whichever source drives the pin.
- R10: For a pin whose analog-configuration bit is 0, the port read and both peripheral inputs return 0.
- R11: A port write to a pin owned by a peripheral leaves `pad_out` and `pad_oe` unchanged. The written value appears on the pin once the peripheral releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 direction, 1 latch, 2 port, 3 analog config |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | PIN_W | Write data |
| bus_rdata | output | PIN_W | Read data for `bus_addr` |
| pera_en | input | PIN_W | Peripheral A ownership request per pin |
| pera_out | input | PIN_W | Peripheral A output data |
| pera_oe | input | PIN_W | Peripheral A output enable |
| pera_in | output | PIN_W | Pin level to peripheral A |
| perb_en | input | PIN_W | Peripheral B ownership request per pin |
| perb_out | input | PIN_W | Peripheral B output data |
| perb_oe | input | PIN_W | Peripheral B output enable |
| perb_in | output | PIN_W | Pin level to peripheral B |
| pad_in | input | PIN_W | Level seen at the pad |
| pad_out | output | PIN_W | Data driven to the pad |
| pad_oe | output | PIN_W | Pad output enable |

## Verification
The assertions assume the following about the inputs:
- `pad_in` and all peripheral inputs are known, never X, at every clock edge after reset.
- Writes happen only through a single-cycle `bus_wr` pulse on a stable `bus_addr`.

The bench meets these assumptions as follows:
- It drives every input at the falling edge from fixed-seed `$urandom` values or directed patterns.
- It holds `bus_wr` for exactly one rising edge per write.
- It never leaves an input undriven after reset.

The synchronizer check assumes `pad_in` was known for two edges before it applies, so it is armed only two cycles after reset.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

    typedef enum logic [1:0] {
        OWN_PORT = 2'd0,
        OWN_PERB = 2'd1,
        OWN_PERA = 2'd2
    } owner_e;

    typedef enum logic [1:0] {
        REG_DIR   = 2'd0,
        REG_LAT   = 2'd1,
        REG_PORT  = 2'd2,
        REG_ANCFG = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs
    import pinmux_pkg::*;
#(
    parameter int PIN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [PIN_W-1:0] bus_wdata,
    output logic [PIN_W-1:0] dir_q,
    output logic [PIN_W-1:0] lat_q,
    output logic [PIN_W-1:0] an_q
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(bus_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '1;
            lat_q <= '0;
            an_q  <= '0;
        end else if (bus_wr) begin
            unique case (sel)
                REG_DIR:   dir_q <= bus_wdata;
                REG_LAT:   lat_q <= bus_wdata;
                REG_PORT:  lat_q <= bus_wdata;
                REG_ANCFG: an_q  <= bus_wdata;
            endcase
        end
    end

    // R6: a write to either latch alias lands in the latch
    assert_latch_alias_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == 2'd1 || bus_addr == 2'd2)) |=> (lat_q == $past(bus_wdata)));

endmodule

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
    parameter int PIN_W  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] d,
    output logic [PIN_W-1:0] q
);

    logic [PIN_W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];

    // Age counter arms the delay check once two edges have passed since reset
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R8: output is the input from two edges earlier
    assert_sync_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (q == $past(d, 2)));

endmodule

// File: rtl/pinmux_owner.sv
module pinmux_owner
    import pinmux_pkg::*;
#(
    parameter int PIN_W = 4
) (
    input  logic [PIN_W-1:0] pera_en,
    input  logic [PIN_W-1:0] pera_out,
    input  logic [PIN_W-1:0] pera_oe,
    input  logic [PIN_W-1:0] perb_en,
    input  logic [PIN_W-1:0] perb_out,
    input  logic [PIN_W-1:0] perb_oe,
    input  logic [PIN_W-1:0] dir_q,
    input  logic [PIN_W-1:0] lat_q,
    output logic [PIN_W-1:0] pad_out,
    output logic [PIN_W-1:0] pad_oe
);

    for (genvar i = 0; i < PIN_W; i++) begin : g_pin
        owner_e own;
        logic   out_b;
        logic   oe_b;

        // ownership state: fixed priority A over B over port
        always_comb begin
            if (pera_en[i])      own = OWN_PERA;
            else if (perb_en[i]) own = OWN_PERB;
            else                 own = OWN_PORT;
        end

        // data chain and enable chain driven by the owner
        always_comb begin
            unique case (own)
                OWN_PERA: begin out_b = pera_out[i]; oe_b = pera_oe[i]; end
                OWN_PERB: begin out_b = perb_out[i]; oe_b = perb_oe[i]; end
                default:  begin out_b = lat_q[i];    oe_b = ~dir_q[i];  end
            endcase
        end

        assign pad_out[i] = out_b;
        assign pad_oe[i]  = oe_b;
    end

endmodule

// File: rtl/shared_pin_mux.sv
module shared_pin_mux
    import pinmux_pkg::*;
#(
    parameter int PIN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [PIN_W-1:0] bus_wdata,
    output logic [PIN_W-1:0] bus_rdata,
    input  logic [PIN_W-1:0] pera_en,
    input  logic [PIN_W-1:0] pera_out,
    input  logic [PIN_W-1:0] pera_oe,
    output logic [PIN_W-1:0] pera_in,
    input  logic [PIN_W-1:0] perb_en,
    input  logic [PIN_W-1:0] perb_out,
    input  logic [PIN_W-1:0] perb_oe,
    output logic [PIN_W-1:0] perb_in,
    input  logic [PIN_W-1:0] pad_in,
    output logic [PIN_W-1:0] pad_out,
    output logic [PIN_W-1:0] pad_oe
);

    localparam int SYNC_STAGES = 2;

    logic [PIN_W-1:0] dir_q, lat_q, an_q;
    logic [PIN_W-1:0] pin_sync;
    logic [PIN_W-1:0] dig_in;
    reg_sel_e         rd_sel;

    pinmux_regs #(.PIN_W(PIN_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .dir_q    (dir_q),
        .lat_q    (lat_q),
        .an_q     (an_q)
    );

    pinmux_sync #(.PIN_W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pad_in),
        .q    (pin_sync)
    );

    pinmux_owner #(.PIN_W(PIN_W)) u_owner (
        .pera_en (pera_en),
        .pera_out(pera_out),
        .pera_oe (pera_oe),
        .perb_en (perb_en),
        .perb_out(perb_out),
        .perb_oe (perb_oe),
        .dir_q   (dir_q),
        .lat_q   (lat_q),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    // digital input gate: analog pins read as 0
    assign dig_in  = pad_in & an_q;
    assign pera_in = dig_in;
    assign perb_in = dig_in;

    assign rd_sel = reg_sel_e'(bus_addr);
    always_comb begin
        unique case (rd_sel)
            REG_DIR:   bus_rdata = dir_q;
            REG_LAT:   bus_rdata = lat_q;
            REG_PORT:  bus_rdata = pin_sync & an_q;
            REG_ANCFG: bus_rdata = an_q;
        endcase
    end

    // R5: where both peripherals request, A's data and enable reach the pad
    assert_a_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (((pera_en & perb_en) & ((pad_out ^ pera_out) | (pad_oe ^ pera_oe))) == '0));

    // R4: B drives pins it alone requests
    assert_b_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (((~pera_en & perb_en) & ((pad_out ^ perb_out) | (pad_oe ^ perb_oe))) == '0));

    // R2: with no peripheral enabled, direction register gates the enable
    assert_port_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pera_en | perb_en) == '0) |-> (pad_oe == ~dir_q));

    // R10: analog pins present 0 on peripheral inputs
    assert_analog_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (((pera_in | perb_in) & ~an_q) == '0));

    // R11: a port write on a peripheral-owned pin does not move the pad
    assert_port_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && (pera_en == '1)) |=>
        ((pera_en != '1) || $changed(pera_out) || $changed(pera_oe) || $stable(pad_out)));

endmodule

// File: tb/tb_shared_pin_mux.sv
module tb_shared_pin_mux;
    localparam int PIN_W    = 4;
    localparam int CLK_PER  = 10;
    localparam int N_RANDOM = 300;

    typedef logic [PIN_W-1:0] vec_t;

    logic clk = 0;
    logic rst_n = 0;
    logic [1:0] bus_addr = 0;
    logic bus_wr = 0;
    vec_t bus_wdata = 0, bus_rdata;
    vec_t pera_en = 0, pera_out = 0, pera_oe = 0, pera_in;
    vec_t perb_en = 0, perb_out = 0, perb_oe = 0, perb_in;
    vec_t pad_in = 0, pad_out, pad_oe;

    int checks = 0;
    int errors = 0;

    vec_t m_dir = '1, m_lat = '0, m_an = '0;

    always #(CLK_PER/2) clk = ~clk;

    shared_pin_mux #(.PIN_W(PIN_W)) dut (.*);

    function automatic vec_t exp_out(vec_t ae, vec_t ao, vec_t be, vec_t bo, vec_t lat);
        return (ae & ao) | (~ae & be & bo) | (~ae & ~be & lat);
    endfunction

    function automatic vec_t exp_oe(vec_t ae, vec_t aoe, vec_t be, vec_t boe, vec_t dir);
        return (ae & aoe) | (~ae & be & boe) | (~ae & ~be & ~dir);
    endfunction

    task automatic chk(string req, vec_t act, vec_t exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] a, vec_t d);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
        case (a)
            2'd0: m_dir = d;
            2'd1, 2'd2: m_lat = d;
            default: m_an = d;
        endcase
    endtask

    task automatic bus_read(logic [1:0] a, output vec_t d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic check_pad(string req);
        #1;
        chk({req, " pad_out"}, pad_out, exp_out(pera_en, pera_out, perb_en, perb_out, m_lat));
        chk({req, " pad_oe"}, pad_oe, exp_oe(pera_en, pera_oe, perb_en, perb_oe, m_dir));
    endtask

    initial begin
        #(CLK_PER * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        vec_t rd;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        bus_read(2'd0, rd); chk("R1 dir", rd, '1);
        bus_read(2'd1, rd); chk("R1 lat", rd, '0);
        bus_read(2'd3, rd); chk("R1 ancfg", rd, '0);
        chk("R1 pad_oe", pad_oe, '0);

        // R7 / R2 port drive
        @(negedge clk);
        bus_write(2'd3, 4'hF);
        bus_write(2'd0, 4'h0);
        bus_write(2'd1, 4'hA);
        bus_read(2'd0, rd); chk("R7 dir readback", rd, 4'h0);
        bus_read(2'd3, rd); chk("R7 ancfg readback", rd, 4'hF);
        bus_read(2'd1, rd); chk("R6 lat readback", rd, 4'hA);
        check_pad("R2 port drive");
        @(negedge clk);
        bus_write(2'd0, 4'h6);
        check_pad("R2 mixed direction");

        // R6 port alias write
        bus_write(2'd2, 4'h5);
        bus_read(2'd1, rd); chk("R6 port alias", rd, 4'h5);

        // R3 A only
        pera_en = 4'hF; pera_out = 4'h3; pera_oe = 4'hC;
        perb_out = 4'h9; perb_oe = 4'h6;
        check_pad("R3 A only");
        chk("R3 explicit out", pad_out, 4'h3);
        // R5 A and B
        perb_en = 4'hF;
        check_pad("R5 both");
        chk("R5 explicit oe", pad_oe, 4'hC);
        // R4 B only
        pera_en = 4'h0;
        check_pad("R4 B only");
        chk("R4 explicit out", pad_out, 4'h9);

        // R11 port write while A owns
        @(negedge clk);
        pera_en = 4'hF; perb_en = 4'h0;
        bus_write(2'd2, 4'hF);
        check_pad("R11 blocked");
        chk("R11 pad unchanged", pad_out, 4'h3);
        pera_en = 4'h0;
        #1;
        chk("R11 released", pad_out, 4'hF);

        // R8 / R9 synchronizer delay
        @(negedge clk);
        pad_in = 4'h9;
        #1;
        chk("R9 pera_in", pera_in, 4'h9);
        chk("R9 perb_in", perb_in, 4'h9);
        @(negedge clk);
        bus_read(2'd2, rd); chk("R8 one edge", rd, 4'h0);
        @(negedge clk);
        bus_read(2'd2, rd); chk("R8 two edges", rd, 4'h9);

        // R10 analog gate
        bus_write(2'd3, 4'h1);
        #1;
        chk("R10 pera_in", pera_in, 4'h1);
        chk("R10 perb_in", perb_in, 4'h1);
        bus_read(2'd2, rd); chk("R10 port read", rd, 4'h1);

        // constrained random mix
        for (int n = 0; n < N_RANDOM; n++) begin
            logic [1:0] a;
            @(negedge clk);
            pera_en = vec_t'($urandom); pera_out = vec_t'($urandom); pera_oe = vec_t'($urandom);
            perb_en = vec_t'($urandom); perb_out = vec_t'($urandom); perb_oe = vec_t'($urandom);
            pad_in  = vec_t'($urandom);
            a = 2'($urandom);
            #1;
            chk("R9 random pera_in", pera_in, pad_in & m_an);
            chk("R10 random perb_in", perb_in, pad_in & m_an);
            bus_write(a, vec_t'($urandom));
            check_pad("R3 random pad");
            bus_read(2'd0, rd); chk("R7 random dir", rd, m_dir);
            bus_read(2'd1, rd); chk("R6 random lat", rd, m_lat);
            bus_read(2'd3, rd); chk("R7 random ancfg", rd, m_an);
            @(negedge clk);
            bus_read(2'd2, rd); chk("R8 random port read", rd, pad_in & m_an);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule